// File: doc/BRIEF.md
# Interrupt Remap Entry Checker

This block resolves a remappable interrupt request against a small on-chip table of 128-bit remap entries. Each request carries a 16-bit entry index, the 16-bit source-id of the requester and a flag that marks a request arriving in the older, non-remappable format. The block reads the indexed entry in the same cycle and checks it in a fixed order: the format flag, the index against the programmed table size, the present bit, the reserved fields, and finally the source-id. One cycle after the request is accepted it raises either a translated interrupt or a fault carrying a numbered reason, the offending index and the source-id.

Software fills the table through a single-entry write port. A 4-bit size field selects a table of 2^(S+1) entries, capped at the physical depth. A mode bit selects a 32-bit destination, or an 8-bit destination taken from bits 15:8 of the entry's destination field. An entry may ask for its own faults to be dropped silently. A request that targets the entry being written in the same cycle is held off until the write has landed.

Top module: `remap_entry_checker`

## Requirements
- R1: After reset no translated interrupt or fault is signalled, every table entry reads as not present, and req_ready is high while no write is in progress.
- R2: A request accepted (req_valid and req_ready high at a clock edge) on a present, well-formed, verified entry raises out_valid for exactly one cycle at the next edge. The entry's low word supplies the output fields: vector in bits 23:16, trigger mode in bit 4, delivery mode in bits 7:5, redirection hint in bit 3, destination mode in bit 2 and destination in bits 63:32. At most one of out_valid and flt_valid is ever high.
- R3: With cfg_x2_mode low, out_dest equals entry bits 47:40 zero-extended to 32 bits. With cfg_x2_mode high it equals entry bits 63:32.
- R4: An index at or above min(2^(cfg_size_s+1), DEPTH) faults with reason 0x21.
- R5: An in-range entry whose present bit (bit 0) is clear faults with reason 0x22.
- R6: A present entry faults with reason 0x20 in any of these cases: a nonzero bit in 15:8, 31:24 or 127:84; a verification type (bits 83:82) of 3; or, with cfg_x2_mode low, a nonzero bit in 63:48 or 39:32.
- R7: With verification type 1, the request source-id must equal entry bits 79:64 on every bit not ignored by the qualifier (bits 81:80). Qualifier 0 ignores nothing, 1 ignores bit 3, 2 ignores bits 3:2 and 3 ignores bits 3:1. A mismatch faults with reason 0x26. Type 0 performs no check.
- R8: With verification type 2, bits 15:8 of the request source-id must lie inclusively between entry bits 79:72 (low bound) and 71:64 (high bound), otherwise the request faults with reason 0x26.
- R9: A request with req_compat high faults with reason 0x25 whatever the index or table contents.
- R10: Only the first failing check is reported, in this order: format flag, index bound, present bit, reserved fields, source verification.
- R11: When the entry's fault-processing-disable bit (bit 1) is set, a present, reserved or verification fault on that entry raises neither out_valid nor flt_valid. Format and index faults are always reported.
- R12: req_ready is low exactly while wr_en is high with wr_idx equal to req_idx. A request accepted after the write sees the new entry.
- R13: flt_idx and flt_sid carry the index and source-id of the request that faulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size_s | input | 4 | Table size field S; 2^(S+1) entries |
| cfg_x2_mode | input | 1 | 1: 32-bit destinations; 0: 8-bit destination in field bits 15:8 |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | AW (5) | Entry written |
| wr_data | input | 128 | New entry contents |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_idx | input | 16 | Entry index of the request |
| req_sid | input | 16 | Requester source-id |
| req_compat | input | 1 | Request is in non-remappable format |
| out_valid | output | 1 | Translated interrupt present |
| out_dest | output | 32 | Destination |
| out_vector | output | 8 | Vector |
| out_trig | output | 1 | Trigger mode |
| out_dlv | output | 3 | Delivery mode |
| out_rh | output | 1 | Redirection hint |
| out_dm | output | 1 | Destination mode |
| flt_valid | output | 1 | Fault present |
| flt_reason | output | 8 | Fault reason code |
| flt_idx | output | 16 | Index of the faulting request |
| flt_sid | output | 16 | Source-id of the faulting request |

## Verification
The checker watches the handshake on every cycle. It confirms that a result never appears without an accepted request, that the two result strobes never coincide and that the hold-off follows a same-index write exactly. It also confirms that the format and index-bound faults follow an accepted request with the right code, and that 8-bit-mode destinations have no upper bits. The qualifier masks, bus-range edges, fault ordering, fault suppression and field extraction depend on table contents. Only the bench's scenarios can show these, and its reference model predicts every response cycle by cycle.

// File: rtl/irc_pkg.sv
package irc_pkg;

    localparam int ENTRY_W = 128;

    localparam logic [7:0] RSN_RSVD   = 8'h20;
    localparam logic [7:0] RSN_BOUND  = 8'h21;
    localparam logic [7:0] RSN_ABSENT = 8'h22;
    localparam logic [7:0] RSN_COMPAT = 8'h25;
    localparam logic [7:0] RSN_SOURCE = 8'h26;

    typedef enum logic [1:0] {
        VT_NONE = 2'd0,
        VT_SID  = 2'd1,
        VT_BUS  = 2'd2,
        VT_BAD  = 2'd3
    } vtype_e;

    // control view of an entry
    typedef struct packed {
        logic present;
        logic fpd;
        logic rsvd;       // reserved regardless of mode
        logic xapic_rsvd; // reserved only with 8-bit destinations
    } ent_ctl_t;

    // verification view of an entry
    typedef struct packed {
        vtype_e      vtype;
        logic [1:0]  qual;
        logic [15:0] exp_sid;
    } ent_vfy_t;

    // delivery view of an entry
    typedef struct packed {
        logic [31:0] dest_raw;
        logic [7:0]  vector;
        logic        trig;
        logic [2:0]  dlv;
        logic        rh;
        logic        dm;
    } ent_irq_t;

    function automatic ent_ctl_t decode_ctl(input logic [ENTRY_W-1:0] raw);
        ent_ctl_t c;
        c.present    = raw[0];
        c.fpd        = raw[1];
        c.rsvd       = (|raw[15:8]) | (|raw[31:24]) | (|raw[127:84]) | (&raw[83:82]);
        c.xapic_rsvd = (|raw[63:48]) | (|raw[39:32]);
        return c;
    endfunction

    function automatic ent_vfy_t decode_vfy(input logic [ENTRY_W-1:0] raw);
        ent_vfy_t v;
        v.vtype   = vtype_e'(raw[83:82]);
        v.qual    = raw[81:80];
        v.exp_sid = raw[79:64];
        return v;
    endfunction

    function automatic ent_irq_t decode_irq(input logic [ENTRY_W-1:0] raw);
        ent_irq_t q;
        q.dest_raw = raw[63:32];
        q.vector   = raw[23:16];
        q.trig     = raw[4];
        q.dlv      = raw[7:5];
        q.rh       = raw[3];
        q.dm       = raw[2];
        return q;
    endfunction

    // bits of the source-id that take part in the comparison
    function automatic logic [15:0] qual_keep(input logic [1:0] q);
        case (q)
            2'd0:    return 16'hFFFF;
            2'd1:    return 16'hFFF7;
            2'd2:    return 16'hFFF3;
            default: return 16'hFFF1;
        endcase
    endfunction

endpackage

// File: rtl/irc_entry_store.sv
module irc_entry_store #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_idx,
    input  logic [irc_pkg::ENTRY_W-1:0] wr_data,
    input  logic [AW-1:0]               rd_idx,
    output logic [irc_pkg::ENTRY_W-1:0] rd_data
);
    logic [irc_pkg::ENTRY_W-1:0] rows [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                rows[g] <= '0;
            end else if (wr_en && wr_idx == AW'(g)) begin
                rows[g] <= wr_data;
            end
        end
    end

    assign rd_data = rows[rd_idx];
endmodule

// File: rtl/irc_source_check.sv
module irc_source_check
    import irc_pkg::*;
(
    input  ent_vfy_t    vfy,
    input  logic [15:0] req_sid,
    output logic        pass
);
    logic [7:0] bus;
    assign bus = req_sid[15:8];

    always_comb begin
        case (vfy.vtype)
            VT_SID:  pass = ((req_sid ^ vfy.exp_sid) & qual_keep(vfy.qual)) == 16'h0000;
            VT_BUS:  pass = (bus >= vfy.exp_sid[15:8]) && (bus <= vfy.exp_sid[7:0]);
            default: pass = 1'b1; // type 3 is caught as a reserved field
        endcase
    end
endmodule

// File: rtl/irc_fault_eval.sv
module irc_fault_eval
    import irc_pkg::*;
(
    input  logic        compat,
    input  logic        in_range,
    input  logic        x2_mode,
    input  ent_ctl_t    ctl,
    input  ent_irq_t    irq_raw,
    input  logic        src_pass,
    output logic        fault,
    output logic        suppress,
    output logic [7:0]  reason,
    output logic [31:0] dest
);
    always_comb begin
        fault    = 1'b1;
        suppress = 1'b0;
        reason   = 8'h00;
        if (compat) begin
            reason = RSN_COMPAT;
        end else if (!in_range) begin
            reason = RSN_BOUND;
        end else begin
            if (!ctl.present) begin
                reason = RSN_ABSENT;
            end else if (ctl.rsvd || (!x2_mode && ctl.xapic_rsvd)) begin
                reason = RSN_RSVD;
            end else if (!src_pass) begin
                reason = RSN_SOURCE;
            end else begin
                fault = 1'b0;
            end
            suppress = fault && ctl.fpd;
        end
    end

    assign dest = x2_mode ? irq_raw.dest_raw : {24'h0, irq_raw.dest_raw[15:8]};
endmodule

// File: rtl/remap_entry_checker.sv
module remap_entry_checker
    import irc_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int IDX_W = 16,
    parameter int SID_W = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int LIM_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         cfg_size_s,
    input  logic               cfg_x2_mode,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_idx,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [IDX_W-1:0]   req_idx,
    input  logic [SID_W-1:0]   req_sid,
    input  logic               req_compat,
    output logic               out_valid,
    output logic [31:0]        out_dest,
    output logic [7:0]         out_vector,
    output logic               out_trig,
    output logic [2:0]         out_dlv,
    output logic               out_rh,
    output logic               out_dm,
    output logic               flt_valid,
    output logic [7:0]         flt_reason,
    output logic [IDX_W-1:0]   flt_idx,
    output logic [SID_W-1:0]   flt_sid
);
    logic [ENTRY_W-1:0] entry;
    logic [4:0]         size_lg;
    logic [LIM_W-1:0]   limit;
    logic               in_range;
    logic               accept;
    logic               src_pass;
    logic               fault;
    logic               suppress;
    logic [7:0]         reason;
    logic [31:0]        dest;
    ent_ctl_t           ctl;
    ent_vfy_t           vfy;
    ent_irq_t           irq_raw;

    // a same-index write holds the request off for a cycle
    assign req_ready = !(wr_en && req_idx == IDX_W'(wr_idx));
    assign accept    = req_valid && req_ready;

    assign size_lg = {1'b0, cfg_size_s} + 5'd1;
    always_comb begin
        if (size_lg >= 5'(AW)) limit = LIM_W'(DEPTH);
        else                   limit = {{IDX_W{1'b0}}, 1'b1} << size_lg;
    end
    assign in_range = {1'b0, req_idx} < limit;

    irc_entry_store #(.DEPTH(DEPTH), .AW(AW)) store_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (req_idx[AW-1:0]),
        .rd_data (entry)
    );

    assign ctl     = decode_ctl(entry);
    assign vfy     = decode_vfy(entry);
    assign irq_raw = decode_irq(entry);

    irc_source_check src_i (
        .vfy     (vfy),
        .req_sid (req_sid),
        .pass    (src_pass)
    );

    irc_fault_eval eval_i (
        .compat   (req_compat),
        .in_range (in_range),
        .x2_mode  (cfg_x2_mode),
        .ctl      (ctl),
        .irq_raw  (irq_raw),
        .src_pass (src_pass),
        .fault    (fault),
        .suppress (suppress),
        .reason   (reason),
        .dest     (dest)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            flt_valid <= 1'b0;
        end else begin
            out_valid <= accept && !fault;
            flt_valid <= accept && fault && !suppress;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_dest   <= '0;
            out_vector <= '0;
            out_trig   <= 1'b0;
            out_dlv    <= '0;
            out_rh     <= 1'b0;
            out_dm     <= 1'b0;
            flt_reason <= '0;
            flt_idx    <= '0;
            flt_sid    <= '0;
        end else if (accept) begin
            out_dest   <= dest;
            out_vector <= irq_raw.vector;
            out_trig   <= irq_raw.trig;
            out_dlv    <= irq_raw.dlv;
            out_rh     <= irq_raw.rh;
            out_dm     <= irq_raw.dm;
            flt_reason <= reason;
            flt_idx    <= req_idx;
            flt_sid    <= req_sid;
        end
    end
endmodule

// File: rtl/irc_checker.sv
module irc_checker #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       cfg_size_s,
    input logic             cfg_x2_mode,
    input logic             wr_en,
    input logic [AW-1:0]    wr_idx,
    input logic             req_valid,
    input logic             req_ready,
    input logic [IDX_W-1:0] req_idx,
    input logic             req_compat,
    input logic             out_valid,
    input logic [31:0]      out_dest,
    input logic             flt_valid,
    input logic [7:0]       flt_reason
);
    logic take;
    int   tbl_entries;
    assign take = req_valid && req_ready;

    always_comb begin
        if (int'(cfg_size_s) + 1 >= AW) tbl_entries = DEPTH;
        else                            tbl_entries = 1 << (int'(cfg_size_s) + 1);
    end

    assert_single_result_R2: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && flt_valid));

    assert_result_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        !take |=> !(out_valid || flt_valid));

    assert_stall_same_index_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(req_idx) == int'(wr_idx)) |-> !req_ready);

    assert_ready_no_write_R12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> req_ready);

    assert_compat_fault_R9: assert property (@(posedge clk) disable iff (rst)
        (take && req_compat) |=> (flt_valid && flt_reason == 8'h25));

    assert_bound_fault_R4: assert property (@(posedge clk) disable iff (rst)
        (take && !req_compat && int'(req_idx) >= tbl_entries) |=> (flt_valid && flt_reason == 8'h21));

    assert_narrow_dest_R3: assert property (@(posedge clk) disable iff (rst)
        (take && !cfg_x2_mode) |=> (!out_valid || out_dest[31:8] == 24'h0));
endmodule

bind remap_entry_checker irc_checker #(.DEPTH(DEPTH), .IDX_W(IDX_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_size_s  (cfg_size_s),
    .cfg_x2_mode (cfg_x2_mode),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_idx     (req_idx),
    .req_compat  (req_compat),
    .out_valid   (out_valid),
    .out_dest    (out_dest),
    .flt_valid   (flt_valid),
    .flt_reason  (flt_reason)
);

// File: tb/remap_entry_checker_tb_top.sv
module remap_entry_checker_tb_top;
    localparam int TB_DEPTH = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   cfg_size_s = 4'd4;
    logic         cfg_x2_mode = 1'b1;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_idx = '0;
    logic [127:0] wr_data = '0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [15:0]  req_idx = '0;
    logic [15:0]  req_sid = '0;
    logic         req_compat = 1'b0;
    logic         out_valid;
    logic [31:0]  out_dest;
    logic [7:0]   out_vector;
    logic         out_trig;
    logic [2:0]   out_dlv;
    logic         out_rh;
    logic         out_dm;
    logic         flt_valid;
    logic [7:0]   flt_reason;
    logic [15:0]  flt_idx;
    logic [15:0]  flt_sid;

    int    checks = 0;
    int    errors = 0;
    bit    running = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    remap_entry_checker dut_i (
        .clk(clk), .rst(rst), .cfg_size_s(cfg_size_s), .cfg_x2_mode(cfg_x2_mode),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_idx(req_idx),
        .req_sid(req_sid), .req_compat(req_compat),
        .out_valid(out_valid), .out_dest(out_dest), .out_vector(out_vector),
        .out_trig(out_trig), .out_dlv(out_dlv), .out_rh(out_rh), .out_dm(out_dm),
        .flt_valid(flt_valid), .flt_reason(flt_reason), .flt_idx(flt_idx), .flt_sid(flt_sid)
    );

    // ---------------- reference model ----------------
    logic [127:0] mdl [TB_DEPTH];
    bit           m_ov, m_fv;
    logic [31:0]  m_dest;
    logic [7:0]   m_vec, m_rsn;
    logic         m_trig, m_rh, m_dm;
    logic [2:0]   m_dlv;
    int           m_idx, m_sid;

    always @(posedge clk) begin : model
        int lim, vt, q, ign, bus;
        logic [63:0] lo, hi;
        bit fl, rsvd, ok;
        if (rst) begin
            m_ov = 0; m_fv = 0;
            for (int i = 0; i < TB_DEPTH; i++) mdl[i] = '0;
        end else begin
            m_ov = 0; m_fv = 0;
            if (req_valid && !(wr_en && int'(req_idx) == int'(wr_idx))) begin
                lim = (int'(cfg_size_s) + 1 >= 5) ? TB_DEPTH : (1 << (int'(cfg_size_s) + 1));
                lo = mdl[int'(req_idx) % TB_DEPTH][63:0];
                hi = mdl[int'(req_idx) % TB_DEPTH][127:64];
                fl = 1;
                m_rsn = 8'h00;
                if (req_compat) m_rsn = 8'h25;
                else if (int'(req_idx) >= lim) m_rsn = 8'h21;
                else begin
                    rsvd = (lo[15:8] != 0) || (lo[31:24] != 0) || (hi[63:20] != 0) ||
                           (hi[19:18] == 2'd3) ||
                           (!cfg_x2_mode && (lo[63:48] != 0 || lo[39:32] != 0));
                    vt = int'(hi[19:18]);
                    q  = int'(hi[17:16]);
                    ign = (q == 0) ? 0 : (q == 1) ? 'h8 : (q == 2) ? 'hC : 'hE;
                    bus = int'(req_sid) >> 8;
                    ok = 1;
                    if (vt == 1) ok = ((int'(req_sid) ^ int'(hi[15:0])) & ~ign & 'hFFFF) == 0;
                    if (vt == 2) ok = (bus >= int'(hi[15:8])) && (bus <= int'(hi[7:0]));
                    if (!lo[0]) m_rsn = 8'h22;
                    else if (rsvd) m_rsn = 8'h20;
                    else if (!ok) m_rsn = 8'h26;
                    else fl = 0;
                    if (fl && lo[1]) fl = 0; else if (!fl) m_ov = 1;
                    if (!fl && m_rsn != 8'h00) m_rsn = 8'h00;
                end
                if (m_rsn != 8'h00) m_fv = 1;
                m_dest = cfg_x2_mode ? lo[63:32] : {24'h0, lo[47:40]};
                m_vec  = lo[23:16];
                m_trig = lo[4];
                m_dlv  = lo[7:5];
                m_rh   = lo[3];
                m_dm   = lo[2];
                m_idx  = int'(req_idx);
                m_sid  = int'(req_sid);
            end
            if (wr_en) mdl[wr_idx] = wr_data;
        end
    end

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
        end
    endtask

    // compare on every clock, 2 ns after the edge
    always @(posedge clk) begin
        #2;
        if (running && !rst) begin
            check(req_ready === !(wr_en && int'(req_idx) == int'(wr_idx)), "ready",
                  longint'(req_ready), longint'(!(wr_en && int'(req_idx) == int'(wr_idx))));
            check(out_valid === m_ov, "out_valid", longint'(out_valid), longint'(m_ov));
            check(flt_valid === m_fv, "flt_valid", longint'(flt_valid), longint'(m_fv));
            if (m_ov && out_valid) begin
                check(out_dest === m_dest, "dest", longint'(out_dest), longint'(m_dest));
                check({out_vector, out_trig, out_dlv, out_rh, out_dm} ===
                      {m_vec, m_trig, m_dlv, m_rh, m_dm}, "fields",
                      longint'({out_vector, out_trig, out_dlv, out_rh, out_dm}),
                      longint'({m_vec, m_trig, m_dlv, m_rh, m_dm}));
            end
            if (m_fv && flt_valid) begin
                check(flt_reason === m_rsn, "reason", longint'(flt_reason), longint'(m_rsn));
                check(int'(flt_idx) == m_idx && int'(flt_sid) == m_sid, "R13 idx/sid",
                      longint'({flt_idx, flt_sid}), longint'({m_idx[15:0], m_sid[15:0]}));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [63:0] mk_lo(input logic [31:0] dest, input logic [7:0] vec,
                                          input logic [2:0] dlv, input bit tm, input bit rh,
                                          input bit dm, input bit fpd, input bit p);
        return {dest, 8'h00, vec, 8'h00, dlv, tm, rh, dm, fpd, p};
    endfunction

    function automatic logic [63:0] mk_hi(input logic [15:0] sid, input logic [1:0] sq,
                                          input logic [1:0] vt);
        return {44'h0, vt, sq, sid};
    endfunction

    task automatic put(input int idx, input logic [63:0] hi, input logic [63:0] lo);
        @(negedge clk);
        wr_en = 1; wr_idx = 5'(idx); wr_data = {hi, lo};
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic ask(input string tag, input int idx, input int sid, input bit compat);
        @(negedge clk);
        cur_tag = tag;
        req_valid = 1; req_idx = 16'(idx); req_sid = 16'(sid); req_compat = compat;
        @(negedge clk);
        req_valid = 0; req_compat = 0;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        cur_tag = "R1";
        check(!out_valid && !flt_valid, "R1 idle outputs", longint'({out_valid, flt_valid}), 0);
        check(req_ready === 1'b1, "R1 ready", longint'(req_ready), 1);
        running = 1;
        ask("R1", 0, 0, 0);                                   // empty table: 0x22

        // R2: 32-bit mode translation
        put(3, mk_hi(0, 0, 0), mk_lo(32'h12345678, 8'h41, 3'd1, 1, 1, 1, 0, 1));
        ask("R2", 3, 16'h0abc, 0);
        put(7, mk_hi(0, 0, 0), mk_lo(32'h0000fe00, 8'hc3, 3'd5, 0, 0, 0, 0, 1));
        ask("R2", 7, 16'h0001, 0);

        // R3: 8-bit destination mode
        cfg_x2_mode = 0;
        ask("R3", 7, 16'h0001, 0);
        ask("R6", 3, 16'h0001, 0);                            // 0x12345678 has bits outside 15:8
        cfg_x2_mode = 1;

        // R4: index bound
        cfg_size_s = 4'd1;
        ask("R4", 3, 0, 0);
        ask("R4", 4, 0, 0);
        ask("R4", 200, 0, 0);
        cfg_size_s = 4'd15;
        ask("R4", 31, 0, 0);
        ask("R4", 32, 0, 0);
        cfg_size_s = 4'd4;

        // R5: present bit clear
        ask("R5", 5, 16'h0022, 0);

        // R6: reserved fields
        put(8, mk_hi(0, 0, 0), mk_lo(32'h1, 8'h10, 3'd0, 0, 0, 0, 0, 1) | 64'h200);
        ask("R6", 8, 0, 0);
        put(9, mk_hi(0, 0, 3), mk_lo(32'h1, 8'h10, 3'd0, 0, 0, 0, 0, 1));
        ask("R6", 9, 0, 0);
        put(9, mk_hi(0, 0, 0) | 64'h0010_0000_0000_0000, mk_lo(32'h1, 8'h10, 3'd0, 0, 0, 0, 0, 1));
        ask("R6", 9, 0, 0);

        // R7: qualifier masks
        for (int q = 0; q < 4; q++) begin
            put(10, mk_hi(16'h0108, 2'(q), 1), mk_lo(32'h2, 8'h20, 3'd0, 0, 0, 0, 0, 1));
            ask("R7", 10, 16'h0108, 0);
            ask("R7", 10, 16'h0100, 0);
            ask("R7", 10, 16'h0104, 0);
            ask("R7", 10, 16'h010a, 0);
            ask("R7", 10, 16'h0109, 0);
        end
        put(10, mk_hi(16'h0108, 0, 0), mk_lo(32'h2, 8'h20, 3'd0, 0, 0, 0, 0, 1));
        ask("R7", 10, 16'hffff, 0);

        // R8: bus range
        put(11, mk_hi(16'h0307, 0, 2), mk_lo(32'h3, 8'h30, 3'd0, 0, 0, 0, 0, 1));
        ask("R8", 11, 16'h0200, 0);
        ask("R8", 11, 16'h03ff, 0);
        ask("R8", 11, 16'h0512, 0);
        ask("R8", 11, 16'h0700, 0);
        ask("R8", 11, 16'h0800, 0);

        // R9: non-remappable format
        ask("R9", 3, 0, 1);
        ask("R9", 300, 0, 1);

        // R10: priority
        put(12, mk_hi(0, 0, 0), 64'h0000_0000_0000_ff00); // absent and reserved
        ask("R10", 12, 0, 0);
        put(12, mk_hi(16'h0001, 0, 1), mk_lo(32'h4, 8'h40, 3'd0, 0, 0, 0, 0, 1) | 64'h100);
        ask("R10", 12, 16'h0002, 0);                      // reserved before source
        cfg_size_s = 4'd0;
        ask("R10", 12, 16'h0002, 0);                      // bound before everything in entry

        // R11: fault-processing-disable
        cfg_size_s = 4'd4;
        put(13, mk_hi(0, 0, 0), mk_lo(32'h5, 8'h50, 3'd0, 0, 0, 0, 1, 0));
        ask("R11", 13, 0, 0);
        put(14, mk_hi(16'h0500, 0, 1), mk_lo(32'h6, 8'h60, 3'd0, 0, 0, 0, 1, 1));
        ask("R11", 14, 16'h0600, 0);
        ask("R11", 14, 16'h0500, 0);
        put(15, mk_hi(0, 0, 3), mk_lo(32'h6, 8'h60, 3'd0, 0, 0, 0, 1, 1));
        ask("R11", 15, 0, 0);
        cfg_size_s = 4'd2;
        ask("R11", 14, 16'h0600, 0);
        ask("R11", 14, 16'h0600, 1);
        cfg_size_s = 4'd4;

        // R12: same-index write holds the request, then it sees the new entry
        @(negedge clk);
        cur_tag = "R12";
        wr_en = 1; wr_idx = 5'd6; wr_data = {mk_hi(0, 0, 0), mk_lo(32'hcafe0001, 8'h66, 3'd2, 1, 0, 1, 0, 1)};
        req_valid = 1; req_idx = 16'd6; req_sid = 16'h0033;
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        req_valid = 0;
        // different index write does not stall
        @(negedge clk);
        wr_en = 1; wr_idx = 5'd20; wr_data = '0;
        req_valid = 1; req_idx = 16'd3;
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        // index whose low bits alias the written row still proceeds
        @(negedge clk);
        wr_en = 1; wr_idx = 5'd3; wr_data = {mk_hi(0, 0, 0), mk_lo(32'h7, 8'h77, 3'd0, 0, 0, 0, 0, 1)};
        req_valid = 1; req_idx = 16'd35;
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        ask("R13", 3, 16'hbeef, 1);

        repeat (4) @(negedge clk);
        running = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule